// File: doc/BRIEF.md
# Systolic SAD Block-Matching Motion Search

This block searches a 32×32 window of a reference frame for the position that best matches a 16×16 block of the current frame. It tries every displacement from −8 to +8 on both axes (289 candidates) and reports the one with the smallest sum of absolute pixel differences (SAD). The match costs against the window are measured with the block centred in the window, so that displacement (0,0) puts block pixel (row r, column c) over window pixel (8+r, 8+c).

Sixteen processing elements are connected in a chain. The block's pixels are read in raster order and pass down the chain through one register per element. Element k therefore sees each block pixel k cycles after the first element does, and it is the element that scores horizontal offset −8+k. On every cycle two window pixels are broadcast to all elements. One comes from the row that the head of the chain is currently reading. The other comes from the row before it and is used by the elements that still hold pixels of that earlier row. Each element accumulates its candidate's SAD and keeps the lowest one it has seen. A final reduction then picks the overall winner.

The block's memories are external and answer within the same cycle. The block drives the pixel addresses and samples the returned pixel bytes in that same cycle.

Top module: `sme_array`

## Requirements
- R1: While reset is held and after it is released, `done` and `fetch` are 0 and `best_sad`, `best_dx` and `best_dy` are 0.
- R2: A `start` seen while idle begins a search. `fetch` is then high for exactly 8704 consecutive cycles, beginning with the cycle after the accepting edge. On the i-th such cycle (i from 0), the block address is column `i mod 16`, row `(i/16) mod 16`. The whole block is therefore read 34 times.
- R3: On fetch cycle i, let pass p = i/256 and v = p/2. The first broadcast address is x = (B + column) mod 32 and y = v + row, where B = 0 for even p and 16 for odd p. Even passes score horizontal offsets −8..7 and odd passes score offset +8 only; the vertical offset is v−8.
- R4: The second broadcast address equals the first broadcast address issued 16 fetch cycles earlier, with x increased by 16 modulo 32.
- R5: `best_sad` equals the minimum over all 289 displacements of the sum of |cur(r,c) − win(8+dy+r, 8+dx+c)|, and `best_dx`/`best_dy` (signed, x horizontal) give a displacement that attains it.
- R6: When several displacements share the minimum, the one reported has the smallest dy, and among those the smallest dx.
- R7: `done` is high for exactly one cycle, set by the 8720th clock edge after the edge that accepted `start`.
- R8: A `start` given while a search is running is ignored: fetching continues unchanged and `done` keeps its original timing.
- R9: `best_dx`, `best_dy` and `best_sad` hold their values after `done` until the next search completes.
- R10: The largest possible SAD, 65280 (all 256 differences equal to 255), is reported without wrap-around.
- R11: The extreme displacements ±8 on both axes, including horizontal +8, can be reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search when idle |
| fetch | output | 1 | Addresses below are valid this cycle |
| cur_x | output | 4 | Block pixel column |
| cur_y | output | 4 | Block pixel row |
| cur_pix | input | 8 | Block pixel at (cur_y, cur_x) |
| sa_a_x | output | 5 | First broadcast window column |
| sa_a_y | output | 5 | First broadcast window row |
| sa_b_x | output | 5 | Second broadcast window column |
| sa_b_y | output | 5 | Second broadcast window row |
| sa_a_pix | input | 8 | Window pixel at the first address |
| sa_b_pix | input | 8 | Window pixel at the second address |
| done | output | 1 | One-cycle result pulse |
| best_dx | output | 5 | Winning horizontal displacement, signed |
| best_dy | output | 5 | Winning vertical displacement, signed |
| best_sad | output | 16 | SAD of the winning displacement |

## Verification
The hardest case to reach is an exact tie between candidates that are scored by different elements in different passes. An example is an odd-pass +8 column tying with an even-pass column on another row, because only then does the final reduction's ordering decide the result. The bench builds such ties on purpose. It plants the same block in two disjoint quadrants of the window, and in other cases it uses flat images where all 289 candidates tie. Further cases plant matches at the corner displacements and fill the block and window with opposite extremes, so that the stored and reported sums reach their largest possible value.

// File: rtl/sme_pkg.sv
package sme_pkg;
    localparam int PIX_W = 8;
    localparam int SAD_W = 16;
    localparam int BLK   = 16;
    localparam int RNG   = 8;
    localparam int NPE   = BLK;
    localparam int CW    = $clog2(BLK);
    localparam int NW    = 2 * CW;
    localparam int AW    = $clog2(2 * BLK);
    localparam int NPASS = 2 * (2 * RNG + 1);
    localparam int PW    = $clog2(NPASS);

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DRAIN} phase_t;

    // travels down the chain alongside each block pixel
    typedef struct packed {
        logic             vld;
        logic             first;
        logic             last;
        logic [AW-1:0]    vy;
        logic             half;
        logic [PIX_W-1:0] pix;
    } tag_t;

    typedef struct packed {
        logic [SAD_W-1:0]     sad;
        logic signed [AW-1:0] dy;
        logic signed [AW-1:0] dx;
        logic                 hit;
    } cand_t;

    function automatic logic [PIX_W-1:0] absdiff(input logic [PIX_W-1:0] a,
                                                 input logic [PIX_W-1:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    // x is preferred over y: lower sum, then lower dy, then lower dx
    function automatic logic beats(input cand_t x, input cand_t y);
        if (!x.hit) return 1'b0;
        if (!y.hit) return 1'b1;
        if (x.sad != y.sad) return x.sad < y.sad;
        if (x.dy != y.dy) return x.dy < y.dy;
        return x.dx < y.dx;
    endfunction
endpackage

// File: rtl/sme_ctrl.sv
module sme_ctrl import sme_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          fetch,
    output logic          clr,
    output logic          fin,
    output logic [CW-1:0] col,
    output logic [CW-1:0] row,
    output logic [AW-1:0] a_x,
    output logic [AW-1:0] a_y,
    output logic [AW-1:0] b_x,
    output logic [AW-1:0] b_y,
    output tag_t          head
);
    phase_t        phase;
    logic [NW-1:0] n;
    logic [PW-1:0] pass;
    logic [CW-1:0] dcnt;
    logic [AW-1:0] prev_y, prev_xb, xb, vy;

    assign col   = n[CW-1:0];
    assign row   = n[NW-1:CW];
    assign fetch = (phase == PH_RUN);
    assign clr   = (phase == PH_IDLE) && start;
    assign fin   = (phase == PH_DRAIN) && (dcnt == CW'(NPE - 1));
    assign vy    = AW'(pass[PW-1:1]);
    assign xb    = pass[0] ? AW'(2 * RNG) : '0;
    assign a_x   = xb + AW'(col);
    assign a_y   = vy + AW'(row);
    // previous row's origin, shifted one block width to the right
    assign b_x   = prev_xb + AW'(col) + AW'(BLK);
    assign b_y   = prev_y;

    always_comb begin
        head = '0;
        if (fetch) begin
            head.vld   = 1'b1;
            head.first = (n == '0);
            head.last  = (n == '1);
            head.vy    = vy;
            head.half  = pass[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            n       <= '0;
            pass    <= '0;
            dcnt    <= '0;
            prev_y  <= '0;
            prev_xb <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_RUN;
                    n     <= '0;
                    pass  <= '0;
                end
                PH_RUN: begin
                    n <= n + NW'(1);
                    if (col == '1) begin
                        prev_y  <= a_y;
                        prev_xb <= xb;
                    end
                    if (n == '1) begin
                        if (pass == PW'(NPASS - 1)) begin
                            phase <= PH_DRAIN;
                            dcnt  <= '0;
                        end else begin
                            pass <= pass + PW'(1);
                        end
                    end
                end
                PH_DRAIN: begin
                    n    <= n + NW'(1);
                    dcnt <= dcnt + CW'(1);
                    if (fin) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    cur_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch && $past(fetch)) |-> ({row, col} == $past({row, col}) + NW'(1)));
    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch && start && n != '1) |=> (fetch && n == $past(n) + NW'(1)));
    // R7
    fin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> !fetch);
endmodule

// File: rtl/sme_pe.sv
module sme_pe import sme_pkg::*; #(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  tag_t             tin,
    input  logic [CW-1:0]    col,
    input  logic [PIX_W-1:0] a_pix,
    input  logic [PIX_W-1:0] b_pix,
    output tag_t             tout,
    output cand_t            best
);
    localparam logic [CW-1:0] KID   = CW'(IDX);
    localparam int            DXLO  = IDX - RNG;
    localparam int            DXHI  = IDX + RNG;
    localparam bit            HI_OK = (DXHI <= RNG);

    logic             use_b, live;
    logic [PIX_W-1:0] ref_pix, dif;
    logic [SAD_W-1:0] acc, sum;
    cand_t            cand;

    // elements still holding last row's pixel take the second broadcast
    if (IDX == 0) begin : g_head
        assign use_b = 1'b0;
    end else begin : g_body
        assign use_b = (col < KID);
    end

    always_comb begin
        ref_pix  = use_b ? b_pix : a_pix;
        dif      = absdiff(tin.pix, ref_pix);
        sum      = (tin.first ? '0 : acc) + SAD_W'(dif);
        live     = tin.half ? HI_OK : 1'b1;
        cand.sad = sum;
        cand.dy  = $signed(tin.vy - AW'(RNG));
        cand.dx  = tin.half ? AW'(DXHI) : AW'(DXLO);
        cand.hit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tout <= '0;
            acc  <= '0;
            best <= '0;
        end else begin
            tout <= tin;
            if (tin.vld) acc <= sum;
            if (clr)
                best.hit <= 1'b0;
            else if (tin.vld && tin.last && live && (!best.hit || sum < best.sad))
                best <= cand;
        end
    end

    // R6
    min_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (best.hit && $past(best.hit) && !$past(clr)) |-> (best.sad <= $past(best.sad)));
    // R10
    acc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tin.vld && !tin.first) |-> (sum >= acc));
endmodule

// File: rtl/sme_best.sv
module sme_best import sme_pkg::*; (
    input  cand_t cands [NPE],
    output cand_t win
);
    always_comb begin
        win = cands[0];
        for (int i = 1; i < NPE; i++)
            if (beats(cands[i], win)) win = cands[i];
    end
endmodule

// File: rtl/sme_array.sv
module sme_array import sme_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    output logic                    fetch,
    output logic [CW-1:0]           cur_x,
    output logic [CW-1:0]           cur_y,
    input  logic [PIX_W-1:0]        cur_pix,
    output logic [AW-1:0]           sa_a_x,
    output logic [AW-1:0]           sa_a_y,
    output logic [AW-1:0]           sa_b_x,
    output logic [AW-1:0]           sa_b_y,
    input  logic [PIX_W-1:0]        sa_a_pix,
    input  logic [PIX_W-1:0]        sa_b_pix,
    output logic                    done,
    output logic signed [AW-1:0]    best_dx,
    output logic signed [AW-1:0]    best_dy,
    output logic [SAD_W-1:0]        best_sad
);
    logic    clr, fin;
    logic [CW-1:0] col;
    tag_t    head, tail;
    tag_t    link [NPE];
    cand_t   cands [NPE];
    cand_t   win;

    sme_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .fetch(fetch), .clr(clr), .fin(fin),
        .col(col), .row(cur_y), .a_x(sa_a_x), .a_y(sa_a_y), .b_x(sa_b_x), .b_y(sa_b_y),
        .head(head)
    );
    assign cur_x = col;

    always_comb begin
        link[0]     = head;
        link[0].pix = fetch ? cur_pix : '0;
    end

    for (genvar k = 0; k < NPE; k++) begin : g_pe
        tag_t nxt;
        sme_pe #(.IDX(k)) u_pe (
            .clk(clk), .rst(rst), .clr(clr), .tin(link[k]), .col(col),
            .a_pix(sa_a_pix), .b_pix(sa_b_pix), .tout(nxt), .best(cands[k])
        );
        if (k < NPE - 1) begin : g_link
            assign link[k+1] = nxt;
        end else begin : g_tail
            assign tail = nxt;
        end
    end

    sme_best u_best (.cands(cands), .win(win));

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            best_dx  <= '0;
            best_dy  <= '0;
            best_sad <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                best_dx  <= win.dx;
                best_dy  <= win.dy;
                best_sad <= win.sad;
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (tail == '0));
    // R5
    win_found_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> win.hit);
    // R11
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(best_dx) >= -RNG && int'(best_dx) <= RNG &&
                  int'(best_dy) >= -RNG && int'(best_dy) <= RNG));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(fin) |-> $stable(best_sad));
endmodule

// File: tb/sme_array_test.sv
module sme_array_test;
    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic fetch, done;
    logic [3:0] cur_x, cur_y;
    logic [4:0] sa_a_x, sa_a_y, sa_b_x, sa_b_y;
    logic [7:0] cur_pix, sa_a_pix, sa_b_pix;
    logic signed [4:0] best_dx, best_dy;
    logic [15:0] best_sad;

    logic [7:0] cm [16][16];
    logic [7:0] sm [32][32];

    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    assign cur_pix  = cm[cur_y][cur_x];
    assign sa_a_pix = sm[sa_a_y][sa_a_x];
    assign sa_b_pix = sm[sa_b_y][sa_b_x];

    sme_array uut (
        .clk(clk), .rst(rst), .start(start), .fetch(fetch),
        .cur_x(cur_x), .cur_y(cur_y), .cur_pix(cur_pix),
        .sa_a_x(sa_a_x), .sa_a_y(sa_a_y), .sa_b_x(sa_b_x), .sa_b_y(sa_b_y),
        .sa_a_pix(sa_a_pix), .sa_b_pix(sa_b_pix),
        .done(done), .best_dx(best_dx), .best_dy(best_dy), .best_sad(best_sad)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model(output int bx, output int by, output int bs);
        bs = 32'h7fffffff; bx = 0; by = 0;
        for (int dy = -8; dy <= 8; dy++)
            for (int dx = -8; dx <= 8; dx++) begin
                int s = 0;
                for (int r = 0; r < 16; r++)
                    for (int c = 0; c < 16; c++) begin
                        int d = int'(cm[r][c]) - int'(sm[8+dy+r][8+dx+c]);
                        s += (d < 0) ? -d : d;
                    end
                if (s < bs) begin bs = s; bx = dx; by = dy; end
            end
    endtask

    task automatic fill(input int cv, input int sv);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                cm[r][c] = (cv < 0) ? 8'($urandom_range(0, 255)) : 8'(cv);
        for (int r = 0; r < 32; r++)
            for (int c = 0; c < 32; c++)
                sm[r][c] = (sv < 0) ? 8'($urandom_range(0, 255)) : 8'(sv);
    endtask

    task automatic plant(input int dx, input int dy);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                sm[8+dy+r][8+dx+c] = cm[r][c];
    endtask

    task automatic run_case(input string req, input int poke);
        int ex, ey, es;
        int hx, hy, hs;
        model(ex, ey, es);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 1; k <= 8726; k++) begin
            bit ef;
            int i, c, r, p, xb;
            ef = (k <= 8704);
            i  = k - 1;
            chk(fetch == ef, "R2 fetch window", int'(fetch), int'(ef));
            if (ef) begin
                c = i % 16; r = (i / 16) % 16; p = i / 256;
                xb = (p % 2 == 1) ? 16 : 0;
                chk(cur_x == 4'(c), "R2 block column", int'(cur_x), c);
                chk(cur_y == 4'(r), "R2 block row", int'(cur_y), r);
                chk(sa_a_x == 5'((xb + c) % 32), "R3 first x", int'(sa_a_x), (xb + c) % 32);
                chk(sa_a_y == 5'(p / 2 + r), "R3 first y", int'(sa_a_y), p / 2 + r);
                if (i >= 16) begin
                    int pp, rr, xx;
                    pp = (i - 16) / 256; rr = ((i - 16) / 16) % 16;
                    xx = ((pp % 2 == 1) ? 16 : 0) + c + 16;
                    chk(sa_b_x == 5'(xx % 32), "R4 second x", int'(sa_b_x), xx % 32);
                    chk(sa_b_y == 5'(pp / 2 + rr), "R4 second y", int'(sa_b_y), pp / 2 + rr);
                end
            end
            chk(done == (k == 8721), "R7 done timing", int'(done), int'(k == 8721));
            if (k == 8721) begin
                chk(int'(best_dx) == ex, {req, " best_dx"}, int'(best_dx), ex);
                chk(int'(best_dy) == ey, {req, " best_dy"}, int'(best_dy), ey);
                chk(int'(best_sad) == es, {req, " best_sad"}, int'(best_sad), es);
                hx = int'(best_dx); hy = int'(best_dy); hs = int'(best_sad);
            end
            if (k == 8726) begin
                chk(int'(best_dx) == hx, "R9 hold dx", int'(best_dx), hx);
                chk(int'(best_dy) == hy, "R9 hold dy", int'(best_dy), hy);
                chk(int'(best_sad) == hs, "R9 hold sad", int'(best_sad), hs);
            end
            if (k == poke) start = 1'b1;
            if (k == poke + 1) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(fetch == 1'b0, "R1 fetch", int'(fetch), 0);
        chk(best_sad == 16'd0, "R1 best_sad", int'(best_sad), 0);
        chk(best_dx == 5'sd0 && best_dy == 5'sd0, "R1 vector", int'(best_dx), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fetch == 1'b0 && done == 1'b0, "R1 idle after reset", int'(fetch), 0);

        fill(-1, -1); plant(3, -5);
        run_case("R5 random interior", 0);
        fill(-1, -1); plant(8, 8);
        run_case("R11 corner +8,+8", 0);
        fill(-1, -1); plant(-8, 8);
        run_case("R11 corner -8,+8", 0);
        fill(10, 20);
        run_case("R6 flat tie", 0);
        fill(-1, -1); plant(8, -8); plant(-8, 8);
        run_case("R6 split tie", 0);
        fill(0, 255);
        run_case("R10 R8 max sum with busy start", 100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule